// File: doc/BRIEF.md
# Minimal 8-bit Accumulator Processor Core

This block is the datapath and control of a small accumulator machine. Instructions live in a separate program memory, and each clock edge the block takes in one 9-bit instruction on its own program bus. It decodes the instruction and carries it out in that single cycle. An 8-bit data input can be written into one of three scratch registers. A fourth source select reads a fixed constant of one. That constant is what increment and decrement are built from, because the instruction has no immediate field.

Add, subtract and shift results always land in an 8-bit accumulator, along with a 1-bit carry/borrow flag. The add and subtract go through a ripple-carry chain. The accumulator can be copied back into a scratch register. Data leaves the block through an 8-bit output register, which is written only by an explicit store-to-output instruction.

Instruction layout: bits [8:5] are the opcode, [4:3] select the source, [2:1] select the destination, and [0] is unused. Opcodes: 0 NOP, 1 load input, 2 move accumulator to register, 3 ADD, 4 SUB, 5 INC, 6 DEC, 7 LSR, 8 LSL, 9 OUT. Codes 10 to 15 act as NOP.

Top module: `acc_core`

## Requirements
- R1: A synchronous active-high reset clears the three registers, the accumulator, the flag and the output register to zero. The cleared values are visible on the first falling edge after the reset edge.
- R2: Load-input (opcode 1) writes `data_in` into register R[dst], where dst is 0 to 2. With dst = 3, no register changes.
- R3: Move (opcode 2) copies the accumulator into R[dst], where dst is 0 to 2. With dst = 3, no register changes.
- R4: ADD (opcode 3) sets acc to (acc + src) mod 256. The flag takes the carry out of bit 7.
- R5: SUB (opcode 4) sets acc to (acc - src) mod 256. It is computed as acc + ~src + 1, so the flag is 1 exactly when acc >= src, meaning no borrow.
- R6: INC (opcode 5) and DEC (opcode 6) add or subtract the constant one, whatever the source field holds. Their flag follows the same rule as R4 or R5.
- R7: LSR (opcode 7) sets acc to src shifted right by one with a zero in bit 7, and the flag to src bit 0. LSL (opcode 8) sets acc to src shifted left by one with a zero in bit 0, and the flag to src bit 7.
- R8: OUT (opcode 9) loads the output register from the accumulator. No other instruction changes the output register.
- R9: Source select 3 reads the constant 1. NOP (opcode 0) and opcodes 10 to 15 change no state.
- R10: Load-input, move, OUT and NOP leave both the accumulator and the flag unchanged.
- R11: Each instruction takes effect at the rising edge where it is sampled. The result is visible on the ports one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all state |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 9 | Instruction from the program bus |
| data_in | input | 8 | External data for load-input |
| data_out | output | 8 | Output register |
| acc | output | 8 | Accumulator |
| flag | output | 1 | Carry / no-borrow / shifted-out bit |

## Verification
Operands come from loaded registers, so ADD and SUB are driven both with pairs that wrap past 255 and pairs that stay in range. This separates a correct carry chain from one that drops the carry or inverts the borrow sense. Directed cases run INC from 0xFF and DEC from 0x00, and give INC and DEC a nonzero source field to show that the constant is forced. Shifts use operands with both end bits set, which exposes a wrong fill bit or a wrong flag bit. Random opcodes, including the undefined codes and destination 3, are compared after every instruction against a reference model of the accumulator, flag and output register. Register contents reach those comparisons through later arithmetic.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

   typedef enum logic [3:0] {
      OPC_NOP  = 4'd0,
      OPC_LDIN = 4'd1,
      OPC_MOVA = 4'd2,
      OPC_ADD  = 4'd3,
      OPC_SUB  = 4'd4,
      OPC_INC  = 4'd5,
      OPC_DEC  = 4'd6,
      OPC_LSR  = 4'd7,
      OPC_LSL  = 4'd8,
      OPC_OUT  = 4'd9
   } opc_e;

   typedef enum logic [1:0] {
      FN_ADD = 2'd0,
      FN_SUB = 2'd1,
      FN_LSR = 2'd2,
      FN_LSL = 2'd3
   } alu_fn_e;

   typedef struct packed {
      logic    acc_we;
      alu_fn_e fn;
      logic    force_one;
      logic    rf_we;
      logic    rf_from_in;
      logic    out_we;
   } ctl_t;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
   import acc_core_pkg::*;
#(
   parameter int INSTR_W = 9,
   parameter int OPC_W   = 4,
   parameter int SEL_W   = 2
)(
   input  logic [INSTR_W-1:0] instr,
   output ctl_t               ctl,
   output logic [SEL_W-1:0]   src_sel,
   output logic [SEL_W-1:0]   dst_sel
);
   localparam int OPC_LSB = INSTR_W - OPC_W;
   localparam int SRC_LSB = OPC_LSB - SEL_W;
   localparam int DST_LSB = SRC_LSB - SEL_W;

   generate
      if (DST_LSB < 0) begin : g_bad_fields
         $error("acc_decode: instruction too narrow for its fields");
      end
      if (OPC_W != 4) begin : g_bad_opc
         $error("acc_decode: opcode field must be 4 bits");
      end
   endgenerate

   logic [OPC_W-1:0] opc;
   assign opc     = instr[INSTR_W-1 -: OPC_W];
   assign src_sel = instr[SRC_LSB +: SEL_W];
   assign dst_sel = instr[DST_LSB +: SEL_W];

   always_comb begin
      ctl = '0;
      ctl.fn = FN_ADD;
      case (opc)
         OPC_LDIN: begin ctl.rf_we = 1'b1; ctl.rf_from_in = 1'b1; end
         OPC_MOVA: ctl.rf_we = 1'b1;
         OPC_ADD:  begin ctl.acc_we = 1'b1; ctl.fn = FN_ADD; end
         OPC_SUB:  begin ctl.acc_we = 1'b1; ctl.fn = FN_SUB; end
         OPC_INC:  begin ctl.acc_we = 1'b1; ctl.fn = FN_ADD; ctl.force_one = 1'b1; end
         OPC_DEC:  begin ctl.acc_we = 1'b1; ctl.fn = FN_SUB; ctl.force_one = 1'b1; end
         OPC_LSR:  begin ctl.acc_we = 1'b1; ctl.fn = FN_LSR; end
         OPC_LSL:  begin ctl.acc_we = 1'b1; ctl.fn = FN_LSL; end
         OPC_OUT:  ctl.out_we = 1'b1;
         default:  ctl = '0;
      endcase
   end

   // R9: an instruction writes at most one destination
   always_comb begin
      p_single_dest_r9: assert ($onehot0({ctl.acc_we, ctl.rf_we, ctl.out_we}));
   end

endmodule

// File: rtl/acc_regfile.sv
module acc_regfile #(
   parameter int DATA_W = 8,
   parameter int NREG   = 3,
   parameter int SEL_W  = 2
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [SEL_W-1:0]  wsel,
   input  logic [DATA_W-1:0] wdata,
   input  logic [SEL_W-1:0]  rsel,
   output logic [DATA_W-1:0] rdata
);
   localparam int NSRC = NREG + 1;
   localparam logic [DATA_W-1:0] CONST_ONE = DATA_W'(1);

   generate
      if (NSRC > (1 << SEL_W)) begin : g_bad_sel
         $error("acc_regfile: select too narrow for registers plus constant");
      end
   endgenerate

   logic [NREG-1:0][DATA_W-1:0] regs;

   generate
      for (genvar i = 0; i < NREG; i++) begin : g_reg
         localparam logic [SEL_W-1:0] IDX = SEL_W'(i);
         always_ff @(posedge clk) begin
            if (rst)
               regs[i] <= '0;
            else if (we && wsel == IDX)
               regs[i] <= wdata;
         end
      end
   endgenerate

   always_comb begin
      rdata = CONST_ONE;
      for (int k = 0; k < NREG; k++) begin
         if (rsel == SEL_W'(k)) rdata = regs[k];
      end
   end

   // R2/R3: a write to an unmapped destination leaves all registers as they were
   p_unmapped_dst_r2: assert property (@(posedge clk) disable iff (rst)
      (we && 32'(wsel) >= NREG) |=> $stable(regs));

   // R2: a mapped write lands in the addressed register
   p_write_lands_r3: assert property (@(posedge clk) disable iff (rst)
      (we && 32'(wsel) < NREG) |=> regs[$past(wsel)] == $past(wdata));

endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_core_pkg::*;
#(
   parameter int DATA_W = 8
)(
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  alu_fn_e           fn,
   output logic [DATA_W-1:0] y,
   output logic              cout
);
   generate
      if (DATA_W < 2) begin : g_bad_w
         $error("acc_alu: width must be at least 2");
      end
   endgenerate

   logic              cin;
   logic [DATA_W-1:0] b_eff;
   logic [DATA_W-1:0] sum;
   logic [DATA_W:0]   carry;

   assign cin      = (fn == FN_SUB);
   assign b_eff    = cin ? ~b : b;
   assign carry[0] = cin;

   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_fa
         logic p;
         assign p          = a[i] ^ b_eff[i];
         assign sum[i]     = p ^ carry[i];
         assign carry[i+1] = (a[i] & b_eff[i]) | (p & carry[i]);
      end
   endgenerate

   always_comb begin
      case (fn)
         FN_LSR:  begin y = {1'b0, b[DATA_W-1:1]}; cout = b[0]; end
         FN_LSL:  begin y = {b[DATA_W-2:0], 1'b0}; cout = b[DATA_W-1]; end
         default: begin y = sum; cout = carry[DATA_W]; end
      endcase
   end

   // R4/R5: the ripple chain agrees with a wide arithmetic sum
   always_comb begin
      p_ripple_sum_r4: assert ({carry[DATA_W], sum} ==
         ({1'b0, a} + {1'b0, b_eff} + (DATA_W+1)'(cin)));
   end

endmodule

// File: rtl/acc_core.sv
module acc_core
   import acc_core_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int NREG    = 3,
   parameter int SEL_W   = 2,
   parameter int OPC_W   = 4,
   parameter int INSTR_W = OPC_W + 2*SEL_W + 1
)(
   input  logic               clk,
   input  logic               rst,
   input  logic [INSTR_W-1:0] instr,
   input  logic [DATA_W-1:0]  data_in,
   output logic [DATA_W-1:0]  data_out,
   output logic [DATA_W-1:0]  acc,
   output logic               flag
);
   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   ctl_t              ctl;
   logic [SEL_W-1:0]  src_sel, dst_sel;
   logic [DATA_W-1:0] rf_rdata, operand, rf_wdata, alu_y;
   logic              alu_c;
   logic [DATA_W-1:0] acc_q, dout_q;
   logic              flag_q;

   acc_decode #(.INSTR_W(INSTR_W), .OPC_W(OPC_W), .SEL_W(SEL_W)) u_dec (
      .instr   (instr),
      .ctl     (ctl),
      .src_sel (src_sel),
      .dst_sel (dst_sel)
   );

   assign rf_wdata = ctl.rf_from_in ? data_in : acc_q;

   acc_regfile #(.DATA_W(DATA_W), .NREG(NREG), .SEL_W(SEL_W)) u_rf (
      .clk   (clk),
      .rst   (rst),
      .we    (ctl.rf_we),
      .wsel  (dst_sel),
      .wdata (rf_wdata),
      .rsel  (src_sel),
      .rdata (rf_rdata)
   );

   assign operand = ctl.force_one ? ONE : rf_rdata;

   acc_alu #(.DATA_W(DATA_W)) u_alu (
      .a    (acc_q),
      .b    (operand),
      .fn   (ctl.fn),
      .y    (alu_y),
      .cout (alu_c)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q  <= '0;
         flag_q <= 1'b0;
      end else if (ctl.acc_we) begin
         acc_q  <= alu_y;
         flag_q <= alu_c;
      end
   end

   always_ff @(posedge clk) begin
      if (rst)
         dout_q <= '0;
      else if (ctl.out_we)
         dout_q <= acc_q;
   end

   assign acc      = acc_q;
   assign flag     = flag_q;
   assign data_out = dout_q;

   // R1: reset clears the visible state
   p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> (acc == '0 && data_out == '0 && !flag));

   // R8: output register holds unless a store-to-output is decoded
   p_dout_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !ctl.out_we |=> $stable(data_out));

   // R8: store-to-output takes the accumulator of the issuing cycle
   p_dout_load_r8: assert property (@(posedge clk) disable iff (rst)
      ctl.out_we |=> data_out == $past(acc));

   // R10: non-arithmetic instructions leave accumulator and flag alone
   p_acc_hold_r10: assert property (@(posedge clk) disable iff (rst)
      !ctl.acc_we |=> ($stable(acc) && $stable(flag)));

endmodule

// File: tb/sim_acc_core.sv
`timescale 1ns/1ps
module sim_acc_core;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [8:0] instr = '0;
   logic [7:0] data_in = '0;
   logic [7:0] data_out, acc;
   logic       flag;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [7:0] m_r [3];
   logic [7:0] m_acc, m_dout;
   logic       m_flag;

   always #2.5 clk = ~clk;

   acc_core u0 (
      .clk(clk), .rst(rst), .instr(instr), .data_in(data_in),
      .data_out(data_out), .acc(acc), .flag(flag)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act %0h exp %0h", req, act, exp);
      end
   endtask

   function automatic string tag(logic [3:0] op);
      case (op)
         4'd1: return "R2 load";
         4'd2: return "R3 move";
         4'd3: return "R4 add";
         4'd4: return "R5 sub";
         4'd5, 4'd6: return "R6 incdec";
         4'd7, 4'd8: return "R7 shift";
         4'd9: return "R8 out";
         default: return "R9 nop";
      endcase
   endfunction

   function automatic logic [8:0] mk(logic [3:0] op, logic [1:0] s, logic [1:0] d);
      return {op, s, d, 1'b0};
   endfunction

   task automatic model_reset();
      for (int i = 0; i < 3; i++) m_r[i] = '0;
      m_acc = '0; m_dout = '0; m_flag = 1'b0;
   endtask

   task automatic model_step(logic [8:0] ins, logic [7:0] d);
      logic [3:0] op;
      logic [1:0] s, ds;
      logic [7:0] sv;
      logic [8:0] w;
      op = ins[8:5]; s = ins[4:3]; ds = ins[2:1];
      sv = (s == 2'd3) ? 8'd1 : m_r[s];
      case (op)
         4'd1: if (ds != 2'd3) m_r[ds] = d;
         4'd2: if (ds != 2'd3) m_r[ds] = m_acc;
         4'd3: begin w = {1'b0, m_acc} + {1'b0, sv}; m_acc = w[7:0]; m_flag = w[8]; end
         4'd4: begin m_flag = (m_acc >= sv); m_acc = m_acc - sv; end
         4'd5: begin m_flag = (m_acc == 8'hFF); m_acc = m_acc + 8'd1; end
         4'd6: begin m_flag = (m_acc != 8'h00); m_acc = m_acc - 8'd1; end
         4'd7: begin m_flag = sv[0]; m_acc = {1'b0, sv[7:1]}; end
         4'd8: begin m_flag = sv[7]; m_acc = {sv[6:0], 1'b0}; end
         4'd9: m_dout = m_acc;
         default: ;
      endcase
   endtask

   // R11: drive at a falling edge, the rising edge commits, check at the next falling edge
   task automatic step(logic [3:0] op, logic [1:0] s, logic [1:0] d, logic [7:0] din);
      string t;
      instr = mk(op, s, d);
      data_in = din;
      model_step(instr, din);
      @(negedge clk);
      t = tag(op);
      chk({t, " acc R11"}, 32'(acc), 32'(m_acc));
      chk({t, " flag"}, 32'(flag), 32'(m_flag));
      chk({t, " dout R8"}, 32'(data_out), 32'(m_dout));
   endtask

   task automatic do_reset();
      rst = 1'b1;
      instr = mk(4'd3, 2'd3, 2'd0);
      @(negedge clk);
      @(negedge clk);
      model_reset();
      chk("R1 acc", 32'(acc), 0);
      chk("R1 dout", 32'(data_out), 0);
      chk("R1 flag", 32'(flag), 0);
      rst = 1'b0;
   endtask

   initial begin
      void'($urandom(32'd20240607));
      model_reset();
      @(negedge clk);
      do_reset();
      // R1: registers clear, so adding each gives zero
      step(4'd3, 2'd0, 2'd0, 8'h00);
      step(4'd3, 2'd1, 2'd0, 8'h00);
      step(4'd3, 2'd2, 2'd0, 8'h00);
      // R2: loads, dst 3 discarded
      step(4'd1, 2'd0, 2'd0, 8'hF0);
      step(4'd1, 2'd0, 2'd1, 8'h20);
      step(4'd1, 2'd0, 2'd3, 8'h77);
      step(4'd1, 2'd0, 2'd2, 8'h81);
      // R4: add without and with carry
      step(4'd3, 2'd0, 2'd0, 8'h00);
      step(4'd3, 2'd0, 2'd0, 8'h00);
      // R5: sub no borrow, then borrow
      step(4'd4, 2'd1, 2'd0, 8'h00);
      step(4'd4, 2'd0, 2'd0, 8'h00);
      // R9: source 3 is the constant one
      step(4'd3, 2'd3, 2'd0, 8'h00);
      // R8: store, then hold through other ops
      step(4'd9, 2'd0, 2'd0, 8'h00);
      step(4'd3, 2'd1, 2'd0, 8'h00);
      step(4'd0, 2'd2, 2'd1, 8'h55);
      step(4'd12, 2'd1, 2'd0, 8'h55);
      // R7: shifts with both end bits set
      step(4'd7, 2'd2, 2'd0, 8'h00);
      step(4'd8, 2'd2, 2'd0, 8'h00);
      // R3: move acc to R1, read back
      step(4'd2, 2'd0, 2'd1, 8'h00);
      step(4'd2, 2'd0, 2'd3, 8'h00);
      step(4'd7, 2'd1, 2'd0, 8'h00);
      // R6: INC wrap from FF, DEC wrap from 00, nonzero src field
      step(4'd1, 2'd0, 2'd0, 8'hFF);
      step(4'd4, 2'd2, 2'd0, 8'h00);
      step(4'd3, 2'd0, 2'd0, 8'h00);
      do_reset();
      step(4'd3, 2'd0, 2'd0, 8'h00);
      step(4'd1, 2'd0, 2'd0, 8'hFF);
      step(4'd3, 2'd0, 2'd0, 8'h00);
      step(4'd5, 2'd0, 2'd0, 8'h00);
      step(4'd6, 2'd1, 2'd0, 8'h00);
      step(4'd6, 2'd2, 2'd0, 8'h00);
      step(4'd5, 2'd3, 2'd0, 8'h00);
      step(4'd9, 2'd0, 2'd0, 8'h00);
      // random mix, all opcodes and selects
      for (int n = 0; n < 4000; n++) begin
         step(4'($urandom_range(0, 15)), 2'($urandom_range(0, 3)),
              2'($urandom_range(0, 3)), 8'($urandom_range(0, 255)));
         if (n == 2000) do_reset();
      end
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog all requirements act timeout exp completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule